// File: doc/BRIEF.md
# Associative Memory Road Matcher

This block holds a small bank of track patterns and checks a stream of coarse hit addresses (superstrips) against all of them at once. Every pattern stores one superstrip per detector layer. Each stored value has its own don't-care mask, so a pattern can compare some layers at coarser resolution than others. Hits belong to one event and arrive as (layer, superstrip) words. Each pattern keeps one sticky flag per layer. When the end-of-event marker arrives, a pattern becomes a road if the number of its flagged layers reaches a programmable threshold.

The fired roads are then presented one per cycle, lowest pattern index first. A last flag marks the final road, or stands alone when no road fired. Patterns and the threshold are loaded through a simple write port. The block accepts those writes only while no event is open.

Top module: `am_road_matcher`

## Requirements
- R1: After reset, road_valid and road_last are low, the threshold is NLAYER (8), and every stored superstrip and don't-care mask is zero.
- R2: A hit on layer L sets flag L of pattern P when, for every bit position i where bit i of P's don't-care mask for L is 0, bit i of the hit superstrip equals bit i of P's stored value for L. Bits whose mask bit is 1 are not compared.
- R3: A pattern fires when the number of distinct layers flagged in the event is at least the threshold. Hits may come in any layer order. Repeated hits on one layer count once.
- R4: A threshold write (cfg_thr_we) with a value from 1 to NLAYER is taken while idle. The values 0 and above NLAYER are ignored, and the old threshold stays.
- R5: The first hit after the idle state opens a new event, and all flags from earlier events are cleared at that point.
- R6: In the cycle after the edge that samples evt_end, readout starts. Fired pattern indices appear one per cycle with road_valid high, in ascending order. road_last is high together with the final one.
- R7: An event with no fired pattern gives exactly one readout cycle, with road_last high and road_valid low.
- R8: Pattern and threshold writes made while an event is open or being read out are ignored. A write made while idle takes effect even if the first hit of an event arrives in the same cycle; that hit is compared against the old contents.
- R9: A hit presented in the same cycle as evt_end counts toward that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pat_we | input | 1 | Write one layer of one stored pattern |
| cfg_pat_idx | input | PW | Pattern index to write |
| cfg_layer | input | LW | Layer to write |
| cfg_ss | input | SSW | Stored superstrip value |
| cfg_dc | input | SSW | Don't-care mask; a 1 bit is not compared |
| cfg_thr_we | input | 1 | Threshold write strobe |
| cfg_thr | input | CW | New majority threshold |
| hit_valid | input | 1 | Hit word valid |
| hit_layer | input | LW | Layer of the hit |
| hit_ss | input | SSW | Superstrip of the hit |
| evt_end | input | 1 | End-of-event marker |
| road_valid | output | 1 | A fired road index is presented |
| road_idx | output | PW | Index of the fired pattern |
| road_last | output | 1 | Final readout cycle of the event |

## Verification
Two functions can fall in the same cycle: a configuration write and the first hit of an event, and the final hit and the end-of-event marker. The bench drives a pattern write and a matching hit together while the block is idle. It expects the hit to miss against the old value, and the following event to match against the new one. It also closes events with a hit on the evt_end cycle and expects that layer to count. Each case is judged by the set of road indices read out, their order, and the position of the last flag.

// File: rtl/am_road_matcher.sv
module am_road_matcher #(
  parameter int NPAT   = 16,
  parameter int NLAYER = 8,
  parameter int SSW    = 8,
  localparam int PW = $clog2(NPAT),
  localparam int LW = $clog2(NLAYER),
  localparam int CW = $clog2(NLAYER + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_pat_we,
  input  logic [PW-1:0]  cfg_pat_idx,
  input  logic [LW-1:0]  cfg_layer,
  input  logic [SSW-1:0] cfg_ss,
  input  logic [SSW-1:0] cfg_dc,
  input  logic           cfg_thr_we,
  input  logic [CW-1:0]  cfg_thr,
  input  logic           hit_valid,
  input  logic [LW-1:0]  hit_layer,
  input  logic [SSW-1:0] hit_ss,
  input  logic           evt_end,
  output logic           road_valid,
  output logic [PW-1:0]  road_idx,
  output logic           road_last
);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_READ} st_t;

  st_t st;
  logic [NPAT-1:0][NLAYER-1:0][SSW-1:0] pval, pdc;
  logic [NPAT-1:0][NLAYER-1:0]          flg, nflg;
  logic [NPAT-1:0]                      fire, pend;
  logic [CW-1:0]                        thr;

  wire open_ok = (st != S_READ);
  wire idle    = (st == S_IDLE);
  wire [NPAT-1:0] pend_rest = pend & (pend - 1'b1);

  always_comb begin
    for (int p = 0; p < NPAT; p++) begin
      for (int l = 0; l < NLAYER; l++)
        nflg[p][l] = (idle ? 1'b0 : flg[p][l]) |
                     (hit_valid && open_ok && hit_layer == LW'(l) &&
                      (((hit_ss ^ pval[p][l]) & ~pdc[p][l]) == '0));
      fire[p] = $countones(nflg[p]) >= int'(thr);
    end
  end

  always_comb begin
    road_idx = '0;
    for (int p = NPAT - 1; p >= 0; p--)
      if (pend[p]) road_idx = PW'(p);
  end

  assign road_valid = (st == S_READ) && (pend != '0);
  assign road_last  = (st == S_READ) && (pend_rest == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pval <= '0;
      pdc  <= '0;
      flg  <= '0;
      pend <= '0;
      thr  <= CW'(NLAYER);
    end else begin
      if (idle && cfg_pat_we) begin
        pval[cfg_pat_idx][cfg_layer] <= cfg_ss;
        pdc[cfg_pat_idx][cfg_layer]  <= cfg_dc;
      end
      if (idle && cfg_thr_we && cfg_thr != '0 && int'(cfg_thr) <= NLAYER)
        thr <= cfg_thr;
      if (open_ok) flg <= nflg;
      case (st)
        S_IDLE, S_ACT: begin
          if (evt_end) begin
            st   <= S_READ;
            pend <= fire;
          end else if (hit_valid) begin
            st <= S_ACT;
          end
        end
        default: begin
          pend <= pend_rest;
          if (pend_rest == '0) st <= S_IDLE;
        end
      endcase
    end
  end

  p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (road_valid && !road_last) |=> (road_valid && road_idx > $past(road_idx)));

  p_last_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    road_last |=> (!road_last && !road_valid));

  p_thr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (thr >= CW'(1)) && (int'(thr) <= NLAYER));

  p_thr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(thr));

  p_flags_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ) |=> $stable(flg));

endmodule

// File: tb/am_road_matcher_test.sv
module am_road_matcher_test;
  localparam int NPAT = 16, NLAYER = 8, SSW = 8;
  localparam int PW = 4, LW = 3, CW = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_pat_we = 0, cfg_thr_we = 0, hit_valid = 0, evt_end = 0;
  logic [PW-1:0] cfg_pat_idx = '0;
  logic [LW-1:0] cfg_layer = '0, hit_layer = '0;
  logic [SSW-1:0] cfg_ss = '0, cfg_dc = '0, hit_ss = '0;
  logic [CW-1:0] cfg_thr = '0;
  logic road_valid, road_last;
  logic [PW-1:0] road_idx;

  int errors = 0, checks = 0;

  am_road_matcher #(.NPAT(NPAT), .NLAYER(NLAYER), .SSW(SSW)) uut (.*);

  always #2 clk = ~clk;

  // entry: {target pattern, layer mask, threshold, low-bit offset, duplicate}
  localparam logic [18:0] TBL [0:8] = '{
    {4'd1,  8'hFF, 4'd8, 2'd0, 1'b0},
    {4'd2,  8'h7F, 4'd8, 2'd0, 1'b0},
    {4'd2,  8'h7F, 4'd7, 2'd0, 1'b0},
    {4'd5,  8'h3F, 4'd7, 2'd0, 1'b0},
    {4'd5,  8'h3F, 4'd7, 2'd0, 1'b1},
    {4'd6,  8'h81, 4'd2, 2'd0, 1'b1},
    {4'd13, 8'hFF, 4'd8, 2'd3, 1'b0},
    {4'd4,  8'hFF, 4'd8, 2'd1, 1'b0},
    {4'd0,  8'h01, 4'd1, 2'd0, 1'b0}
  };

  function automatic logic [7:0] bv(int p, int l);
    return 8'((p << 4) | (l << 1) | 1);
  endfunction

  function automatic logic [7:0] bdc(int p);
    return (p >= 12) ? 8'h03 : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr_pat(input int p, input int l, input logic [7:0] v, input logic [7:0] d);
    cfg_pat_we = 1; cfg_pat_idx = PW'(p); cfg_layer = LW'(l); cfg_ss = v; cfg_dc = d;
    @(negedge clk); cfg_pat_we = 0;
  endtask

  task automatic wr_thr(input int t);
    cfg_thr_we = 1; cfg_thr = CW'(t);
    @(negedge clk); cfg_thr_we = 0;
  endtask

  task automatic hit(input int l, input logic [7:0] ss, input bit eend);
    hit_valid = 1; hit_layer = LW'(l); hit_ss = ss; evt_end = eend;
    @(negedge clk); hit_valid = 0; evt_end = 0;
  endtask

  task automatic readout(input logic [15:0] exp, input string req);
    logic [15:0] got = '0;
    bit order_ok = 1, seen_last = 0;
    int prev = -1;
    for (int c = 0; c < NPAT + 2 && !seen_last; c++) begin
      if (road_valid) begin
        got[road_idx] = 1'b1;
        if (int'(road_idx) <= prev) order_ok = 0;
        prev = int'(road_idx);
      end
      if (road_last) seen_last = 1;
      @(negedge clk);
    end
    chk(got == exp, req, got, exp);
    chk(order_ok && seen_last, {req, " R6 order/last"}, {order_ok, seen_last}, 2'b11);
  endtask

  task automatic close_evt(input logic [15:0] exp, input string req);
    evt_end = 1; @(negedge clk); evt_end = 0;
    readout(exp, req);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(!road_valid && !road_last, "R1 idle outputs", {road_valid, road_last}, 0);

    // R1: zeroed bank and default threshold 8: all-zero hits fire every pattern
    for (int l = NLAYER - 1; l >= 0; l--) hit(l, 8'h00, 0);
    close_evt(16'hFFFF, "R1 zero bank");

    for (int p = 0; p < NPAT; p++)
      for (int l = 0; l < NLAYER; l++) wr_pat(p, l, bv(p, l), bdc(p));

    // R1: default threshold 8, seven layers do not fire
    for (int l = 0; l < 7; l++) hit(l, bv(1, l), 0);
    close_evt(16'h0000, "R1 default thr");

    // R2 R3 R4: table walk
    foreach (TBL[i]) begin
      int tp = int'(TBL[i][18:15]);
      logic [7:0] m = TBL[i][14:7];
      int th = int'(TBL[i][6:3]);
      logic [1:0] off = TBL[i][2:1];
      bit dup = TBL[i][0];
      logic [7:0] eff;
      wr_thr(th);
      for (int l = NLAYER - 1; l >= 0; l--)
        if (m[l]) begin
          hit(l, bv(tp, l) ^ {6'd0, off}, 0);
          if (dup) hit(l, bv(tp, l) ^ {6'd0, off}, 0);
        end
      eff = (off != 0 && tp < 12) ? 8'h00 : m;
      close_evt(($countones(eff) >= th) ? (16'h1 << tp) : 16'h0, "R2/R3 table");
    end

    // R6: two roads, interleaved hits, ascending readout
    wr_thr(8);
    for (int l = 0; l < NLAYER; l++) begin hit(l, bv(9, l), 0); hit(7 - l, bv(3, 7 - l), 0); end
    close_evt(16'h0208, "R6 two roads");

    // R7: empty event
    evt_end = 1; @(negedge clk); evt_end = 0;
    chk(road_last && !road_valid, "R7 empty event", {road_valid, road_last}, 2'b01);
    @(negedge clk);
    chk(!road_last && !road_valid, "R7 single cycle", {road_valid, road_last}, 0);

    // R9: final hit together with evt_end
    for (int l = 0; l < 7; l++) hit(l, bv(7, l), 0);
    hit(7, bv(7, 7), 1);
    readout(16'h0080, "R9 hit with end");

    // R5: flags cleared between events
    for (int l = 0; l < 4; l++) hit(l, bv(8, l), 0);
    close_evt(16'h0000, "R5 first half");
    for (int l = 4; l < 8; l++) hit(l, bv(8, l), 0);
    close_evt(16'h0000, "R5 second half");

    // R8: writes during an open event ignored
    hit(0, bv(10, 0), 0);
    wr_pat(10, 0, 8'hEE, 8'h00);
    wr_thr(1);
    hit(0, bv(11, 0), 0);
    for (int l = 1; l < 8; l++) hit(l, bv(10, l), 0);
    close_evt(16'h0400, "R8 write while open");
    hit(0, bv(10, 0), 0);
    for (int l = 1; l < 8; l++) hit(l, bv(10, l), 0);
    close_evt(16'h0400, "R8 bank unchanged");

    // R4: out-of-range thresholds ignored
    wr_thr(0);
    hit(0, bv(11, 0), 0);
    close_evt(16'h0000, "R4 thr zero ignored");
    wr_thr(9);
    hit(0, bv(11, 0), 0);
    close_evt(16'h0000, "R4 thr nine ignored");

    // R8: idle write and first hit in the same cycle
    cfg_pat_we = 1; cfg_pat_idx = 4'd3; cfg_layer = 3'd0; cfg_ss = 8'h5A; cfg_dc = 8'h00;
    hit(0, 8'h5A, 0);
    cfg_pat_we = 0;
    for (int l = 1; l < 8; l++) hit(l, bv(3, l), 0);
    close_evt(16'h0000, "R8 same-cycle old value");
    hit(0, 8'h5A, 0);
    for (int l = 1; l < 8; l++) hit(l, bv(3, l), 0);
    close_evt(16'h0008, "R8 new value applied");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule